// File: doc/BRIEF.md
# Square-Wave Tone Generator with Volume Control

This block drives one output with a periodic waveform for a piezo or magnetic sounder. An 8-bit tone value N sets the period to 2 x (N + 1) clocks, so the output frequency is Fosc / (2 x (N + 1)). With a 76.8 kHz clock, N = 0 gives 38.4 kHz and N = 255 gives 150 Hz. Software writes the tone value first and then raises the run control to start the sound.

In the default shape the output stays high for the first half of each period and low for the second half. A volume mode is also available. In this mode a separate high-time value sets how many clocks of each period the output stays high. That value is clamped to one less than the period, so the output always falls at least once per period.

The tone value, the shape selector and the high-time value are held in a shadow register. This register copies the inputs while the generator is stopped and again at each period boundary while it runs. A change made in the middle of a period therefore never cuts a half-period short.

Top module: `buzzer_tone_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `buz_out` is 0.
- R2: If `tone_run` was 0 at the previous rising edge, `buz_out` is 0. The phase counter restarts from zero, so after a stop and restart the waveform begins again at phase 0.
- R3: With `vol_mode` = 0 and tone value N, `buz_out` is high for N+1 consecutive clocks and then low for N+1 clocks, repeating with period 2(N+1).
- R4: N = 0 makes `buz_out` alternate 1,0,1,0 on consecutive clocks. N = 255 gives 256 high clocks in every 512-clock period.
- R5: A tone value written in the middle of a period takes effect only from phase 0 of the next period. The current period completes with its old length.
- R6: With `vol_mode` = 1, `buz_out` is high for the first D clocks of each 2(N+1)-clock period, where D is `vol_high`.
- R7: With `vol_mode` = 1 and D >= 2(N+1), `buz_out` is high for 2(N+1)-1 clocks and low in the last clock of every period.
- R8: With `vol_mode` = 1 and D = 0, `buz_out` stays 0 while running.
- R9: The first cycle after `tone_run` is sampled high shows phase 0 of the waveform. That cycle is high for any nonzero high time.
- R10: Changes to `vol_mode` or `vol_high` in the middle of a period take effect from phase 0 of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (Fosc) |
| rst | input | 1 | Synchronous active-high reset |
| tone_val | input | 8 | Tone value N; period is 2(N+1) clocks |
| tone_run | input | 1 | 1 runs the generator; 0 holds the output low and clears the phase |
| vol_mode | input | 1 | 0 gives half-period high time; 1 uses `vol_high` |
| vol_high | input | 9 | High clocks per period in volume mode, clamped to period-1 |
| buz_out | output | 1 | Registered tone output |

## Verification
The assertions assume that the tone, mode and high-time inputs can change on any clock. They rely on the shadow register to keep the waveform consistent, so they check that the latched settings stay unchanged between period boundaries. They also assume that reset is synchronous and is held for at least one edge before checking begins. The stimulus changes inputs only on falling edges. It changes the settings in the middle of a period on purpose, both in the default shape and in volume mode, and it toggles the run control between test phases so that every restart starts from a known phase.

// File: rtl/buz_pkg.sv
package buz_pkg;

    localparam int BZ_TONE_W = 8;
    localparam int BZ_PH_W   = BZ_TONE_W + 1;

    typedef struct packed {
        logic                 vol_mode;
        logic [BZ_PH_W-1:0]   vol_high;
        logic [BZ_TONE_W-1:0] reload;
    } tone_cfg_t;

    // Last phase index of a period: 2N+1
    function automatic logic [BZ_PH_W-1:0] last_phase(input logic [BZ_TONE_W-1:0] n);
        return {n, 1'b1};
    endfunction

    // Number of high clocks in one period for the given settings
    function automatic logic [BZ_PH_W-1:0] high_len(input tone_cfg_t c);
        logic [BZ_PH_W-1:0] lp;
        lp = last_phase(c.reload);
        if (c.vol_mode)
            return (c.vol_high > lp) ? lp : c.vol_high;
        else
            return {1'b0, c.reload} + 1'b1;
    endfunction

endpackage

// File: rtl/buz_cfg_shadow.sv
module buz_cfg_shadow
    import buz_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run_i,
    input  logic      wrap_i,
    input  tone_cfg_t cfg_i,
    output tone_cfg_t cfg_o
);
    tone_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (!run_i || wrap_i)
            cfg_q <= cfg_i;
    end

    assign cfg_o = cfg_q;

    // R5, R10: settings frozen inside a running period
    a_r5_cfg_frozen_mid_period: assert property (@(posedge clk) disable iff (rst)
        (run_i && !wrap_i) |=> $stable(cfg_q));

endmodule

// File: rtl/buz_phase_ctr.sv
module buz_phase_ctr
    import buz_pkg::*;
#(
    parameter int PH_W = BZ_PH_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_i,
    input  tone_cfg_t       cfg_i,
    output logic [PH_W-1:0] phase_o,
    output logic            wrap_o
);
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] lp;

    assign lp     = last_phase(cfg_i.reload);
    assign wrap_o = run_i && (phase_q == lp);

    always_ff @(posedge clk) begin
        if (rst || !run_i)
            phase_q <= '0;
        else if (wrap_o)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign phase_o = phase_q;

    // R3: phase never leaves the current period
    a_r3_phase_in_period: assert property (@(posedge clk) disable iff (rst)
        phase_q <= lp);

    // R2: stopped generator restarts at phase zero
    a_r2_phase_cleared: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (phase_q == '0));

endmodule

// File: rtl/buz_wave_out.sv
module buz_wave_out
    import buz_pkg::*;
#(
    parameter int PH_W = BZ_PH_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_i,
    input  logic            wrap_i,
    input  logic [PH_W-1:0] phase_i,
    input  tone_cfg_t       cfg_i,
    output logic            wave_o
);
    logic wave_q;
    logic [PH_W-1:0] hi;

    assign hi = high_len(cfg_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i)
            wave_q <= 1'b0;
        else
            wave_q <= (phase_i < hi);
    end

    assign wave_o = wave_q;

    // R2: output low after a stopped cycle
    a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !wave_q);

    // R7: last clock of each period is always low
    a_r7_last_phase_low: assert property (@(posedge clk) disable iff (rst)
        (run_i && wrap_i) |=> !wave_q);

    // R9: phase 0 is high whenever high time is nonzero
    a_r9_start_high: assert property (@(posedge clk) disable iff (rst)
        (run_i && phase_i == '0 && hi != '0) |=> wave_q);

endmodule

// File: rtl/buzzer_tone_gen.sv
module buzzer_tone_gen
    import buz_pkg::*;
#(
    parameter int TONE_W = BZ_TONE_W,
    localparam int PH_W  = TONE_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TONE_W-1:0] tone_val,
    input  logic              tone_run,
    input  logic              vol_mode,
    input  logic [PH_W-1:0]   vol_high,
    output logic              buz_out
);
    tone_cfg_t       cfg_in;
    tone_cfg_t       cfg_act;
    logic [PH_W-1:0] phase;
    logic            wrap;

    assign cfg_in.vol_mode = vol_mode;
    assign cfg_in.vol_high = vol_high;
    assign cfg_in.reload   = tone_val;

    buz_cfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .run_i  (tone_run),
        .wrap_i (wrap),
        .cfg_i  (cfg_in),
        .cfg_o  (cfg_act)
    );

    buz_phase_ctr #(.PH_W(PH_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .run_i   (tone_run),
        .cfg_i   (cfg_act),
        .phase_o (phase),
        .wrap_o  (wrap)
    );

    buz_wave_out #(.PH_W(PH_W)) u_wave (
        .clk     (clk),
        .rst     (rst),
        .run_i   (tone_run),
        .wrap_i  (wrap),
        .phase_i (phase),
        .cfg_i   (cfg_act),
        .wave_o  (buz_out)
    );

    // R1: output low straight out of reset
    a_r1_reset_low: assert property (@(posedge clk)
        $past(rst) |-> !buz_out);

endmodule

// File: tb/tb_buzzer_tone_gen.sv
module tb_buzzer_tone_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tone_val = '0;
    logic       tone_run = 1'b0;
    logic       vol_mode = 1'b0;
    logic [8:0] vol_high = '0;
    logic       buz_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int  m_ph = 0, m_n = 0, m_mode = 0, m_d = 0;
    bit  m_exp = 0;

    always #5 clk = ~clk;

    buzzer_tone_gen dut (
        .clk(clk), .rst(rst), .tone_val(tone_val), .tone_run(tone_run),
        .vol_mode(vol_mode), .vol_high(vol_high), .buz_out(buz_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        int per, hi;
        cycles++;
        if (rst) begin
            m_ph = 0; m_n = 0; m_mode = 0; m_d = 0; m_exp = 0;
        end else if (!tone_run) begin
            m_exp = 0; m_ph = 0;
            m_n = tone_val; m_mode = vol_mode; m_d = vol_high;
        end else begin
            per = 2 * (m_n + 1);
            if (m_mode != 0) hi = (m_d < per) ? m_d : per - 1;
            else             hi = m_n + 1;
            m_exp = (m_ph < hi);
            if (m_ph == per - 1) begin
                m_ph = 0; m_n = tone_val; m_mode = vol_mode; m_d = vol_high;
            end else begin
                m_ph++;
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (!rst) check(buz_out == m_exp, cur_req, buz_out, m_exp);
    end

    // watchdog
    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic restart(input int n, input bit mode, input int d);
        @(negedge clk);
        tone_run = 1'b0; tone_val = n[7:0]; vol_mode = mode; vol_high = d[8:0];
        @(negedge clk);
        tone_run = 1'b1;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1 h += buz_out;
        end
    endtask

    initial begin
        int h;
        // R1: reset state
        wait_cyc(3);
        #1 check(buz_out == 1'b0, "R1", buz_out, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1 check(buz_out == 1'b0, "R1", buz_out, 0);

        // R3: default half-period shape, N=3
        cur_req = "R3";
        restart(3, 1'b0, 0);
        count_high(8, h);  check(h == 4, "R3", h, 4);
        count_high(16, h); check(h == 8, "R3", h, 8);

        // R2: stopped output stays low, then restarts at phase 0
        cur_req = "R2";
        @(negedge clk); tone_run = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1 check(buz_out == 1'b0, "R2", buz_out, 0);
        end
        tone_run = 1'b1;
        cur_req = "R9";
        @(negedge clk); #1 check(buz_out == 1'b1, "R9", buz_out, 1);
        count_high(7, h); check(h == 3, "R2", h, 3);

        // R4: fastest tone alternates every clock
        cur_req = "R4";
        restart(0, 1'b0, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1 check(buz_out == ((i % 2) == 0), "R4", buz_out, (i % 2) == 0);
        end
        // R4: slowest tone
        restart(255, 1'b0, 0);
        count_high(512, h); check(h == 256, "R4", h, 256);

        // R5: tone change mid-period waits for the boundary
        cur_req = "R5";
        restart(5, 1'b0, 0);
        count_high(3, h); check(h == 3, "R5", h, 3);
        tone_val = 8'd1;
        count_high(9, h); check(h == 3, "R5", h, 3);
        count_high(4, h); check(h == 2, "R5", h, 2);

        // R6: volume mode high time
        cur_req = "R6";
        restart(3, 1'b1, 3);
        count_high(8, h);  check(h == 3, "R6", h, 3);
        count_high(16, h); check(h == 6, "R6", h, 6);

        // R7: clamp keeps one low clock per period
        cur_req = "R7";
        restart(3, 1'b1, 100);
        count_high(7, h); check(h == 7, "R7", h, 7);
        @(negedge clk); #1 check(buz_out == 1'b0, "R7", buz_out, 0);
        count_high(8, h); check(h == 7, "R7", h, 7);

        // R8: zero high time silences the output
        cur_req = "R8";
        restart(3, 1'b1, 0);
        count_high(16, h); check(h == 0, "R8", h, 0);

        // R10: high-time change mid-period waits for the boundary
        cur_req = "R10";
        restart(3, 1'b1, 6);
        count_high(2, h); check(h == 2, "R10", h, 2);
        vol_high = 9'd1;
        count_high(6, h); check(h == 4, "R10", h, 4);
        count_high(8, h); check(h == 1, "R10", h, 1);
        // R10: mode switch back to half-period at the boundary
        vol_mode = 1'b0;
        count_high(3, h); check(h == 1, "R10", h, 1);
        count_high(5, h); check(h == 0, "R10", h, 0);
        count_high(8, h); check(h == 4, "R10", h, 4);

        @(negedge clk); tone_run = 1'b0;
        wait_cyc(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule